// File: doc/BRIEF.md
# Flash Erase Command Gatekeeper

This block stands between the register file of a CPU and the erase controls of an on-chip flash array. Software arms an erase by writing the page-number register or setting the mass-erase enable, opens the lock by loading the unlock code, and then writes a trigger byte. The block issues a one-cycle page-erase or mass-erase start pulse toward the flash only when that byte is one of two exact values and every required setup step has taken place. Any other trigger byte is ignored.

Arming is single-use. An accepted erase clears both arming flags on the same clock edge that raises the start pulse, so each later erase needs fresh setup. A request that is otherwise valid but arrives while the flash reports busy is dropped, keeps its arming, and sets a sticky flag that software clears by reading it.

Top module: `flash_erase_gate`

## Requirements
- R1: With the unlock code at 2, the page flag armed and the flash idle, a trigger write of 0x55 raises `page_erase_go` in the cycle after the write. `page_num` then holds the last page number written, from 0 to 63.
- R2: With the unlock code at 2, the mass flag armed, `dbg_port_en` high and the flash idle, a trigger write of 0xAA raises `mass_erase_go` in the cycle after the write.
- R3: A trigger write of any value other than 0x55 or 0xAA gives no start pulse and no reject flag, and it leaves both arming flags unchanged.
- R4: A trigger write of 0x55 gives no page erase if the page-number register has not been written since reset or since the last accepted erase.
- R5: A trigger write of 0xAA gives no mass erase if the mass enable is not set or `dbg_port_en` is low. Writing 0 to the mass enable disarms it.
- R6: The 4-bit unlock code resets to 0 and reads back on `unlock_code`. `unlocked` is high only while the code equals 2. While the code is any other value, no erase is started.
- R7: An accepted erase of either kind clears `page_armed` and `mass_armed`. Both flags read 0 in the cycle of the start pulse, and a repeated trigger without new setup gives no erase.
- R8: A request that meets every other condition while `flash_busy` is high is dropped. It sets `reject_flag` and leaves the arming flags intact. A `reject_rd` strobe clears the flag one cycle later, but a new rejection in the same cycle keeps it set.
- R9: After reset, every output is 0.
- R10: A start pulse lasts exactly one cycle, and the page and mass pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_we | input | 1 | Write strobe for the erase-trigger register |
| trig_data | input | 8 | Trigger byte |
| page_we | input | 1 | Write strobe for the page-number register (arms a page erase) |
| page_data | input | 6 | Page number |
| mass_we | input | 1 | Write strobe for the mass-erase enable |
| mass_data | input | 1 | Value of the mass-erase enable |
| key_we | input | 1 | Write strobe for the unlock code |
| key_data | input | 4 | Unlock code value |
| dbg_port_en | input | 1 | Debug port enabled |
| flash_busy | input | 1 | Flash macro busy |
| reject_rd | input | 1 | Read strobe that clears the reject flag |
| page_erase_go | output | 1 | One-cycle page-erase start |
| page_num | output | 6 | Page to erase, valid with `page_erase_go` |
| mass_erase_go | output | 1 | One-cycle mass-erase start |
| page_armed | output | 1 | Page-erase arming flag |
| mass_armed | output | 1 | Mass-erase arming flag |
| unlocked | output | 1 | The unlock code allows modification |
| unlock_code | output | 4 | Read-back of the unlock code |
| reject_flag | output | 1 | Sticky flag: a request was dropped because the flash was busy |

## Verification
Every result is registered once. A register or trigger write driven in one cycle is visible on the status outputs, the start pulses and `reject_flag` in the next cycle. The bench drives each write for one cycle on a falling edge and samples at the following falling edge, which is exactly one register stage later. It samples again one cycle after that to confirm that a start pulse has fallen. A reject-flag clear is checked at the same one-cycle distance from its read strobe.

// File: rtl/egate_pkg.sv
package egate_pkg;
  localparam logic [7:0] TRIG_PAGE = 8'h55;
  localparam logic [7:0] TRIG_MASS = 8'hAA;

  typedef enum logic [1:0] {
    ERQ_NONE = 2'd0,
    ERQ_PAGE = 2'd1,
    ERQ_MASS = 2'd2
  } erase_req_e;

  // Map a trigger write onto a request kind; only exact bytes count.
  function automatic erase_req_e classify_trigger(input logic we, input logic [7:0] value);
    erase_req_e kind;
    kind = ERQ_NONE;
    if (we) begin
      if (value == TRIG_PAGE)      kind = ERQ_PAGE;
      else if (value == TRIG_MASS) kind = ERQ_MASS;
    end
    return kind;
  endfunction
endpackage

// File: rtl/egate_decode.sv
module egate_decode
  import egate_pkg::*;
(
  input  logic       trig_we,
  input  logic [7:0] trig_data,
  output erase_req_e req,
  output logic       want_page,
  output logic       want_mass
);
  always_comb begin
    req       = classify_trigger(trig_we, trig_data);
    want_page = (req == ERQ_PAGE);
    want_mass = (req == ERQ_MASS);
  end
endmodule

// File: rtl/egate_arming.sv
module egate_arming #(
  parameter int PAGE_W   = 6,
  parameter int KEY_W    = 4,
  parameter int KEY_OPEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_data,
  input  logic              mass_we,
  input  logic              mass_data,
  input  logic              key_we,
  input  logic [KEY_W-1:0]  key_data,
  input  logic              consume,
  output logic              page_armed,
  output logic              mass_armed,
  output logic [PAGE_W-1:0] page_addr,
  output logic [KEY_W-1:0]  key_code,
  output logic              unlocked
);
  localparam logic [KEY_W-1:0] KEY_MATCH = KEY_W'(KEY_OPEN);

  // Page register and its one-shot arming; consumption beats a same-cycle write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_addr  <= '0;
      page_armed <= 1'b0;
    end else begin
      if (page_we) page_addr <= page_data;
      if (consume)      page_armed <= 1'b0;
      else if (page_we) page_armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mass_armed <= 1'b0;
    else if (consume) mass_armed <= 1'b0;
    else if (mass_we) mass_armed <= mass_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_code <= '0;
    else if (key_we) key_code <= key_data;
  end

  assign unlocked = (key_code == KEY_MATCH);

  // R7: an accepted erase leaves both arming flags cleared
  p_consume_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (!page_armed && !mass_armed));
  // R6: unlock code follows its writes
  p_key_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_we |=> (key_code == $past(key_data)));
endmodule

// File: rtl/egate_issue.sv
module egate_issue
  import egate_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  erase_req_e        req,
  input  logic              page_armed,
  input  logic              mass_armed,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic              unlocked,
  input  logic              dbg_en,
  input  logic              busy,
  input  logic              rej_rd,
  output logic              consume,
  output logic              page_go,
  output logic [PAGE_W-1:0] page_num,
  output logic              mass_go,
  output logic              reject_flag
);
  logic qual_page, qual_mass, qualified, accept, drop;

  always_comb begin
    qual_page = (req == ERQ_PAGE) && unlocked && page_armed;
    qual_mass = (req == ERQ_MASS) && unlocked && mass_armed && dbg_en;
    qualified = qual_page || qual_mass;
    accept    = qualified && !busy;
    drop      = qualified && busy;
  end

  assign consume = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_go  <= 1'b0;
      mass_go  <= 1'b0;
      page_num <= '0;
    end else begin
      page_go <= accept && qual_page;
      mass_go <= accept && qual_mass;
      if (accept && qual_page) page_num <= page_addr;
    end
  end

  // A new rejection takes priority over a clearing read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reject_flag <= 1'b0;
    else if (drop)   reject_flag <= 1'b1;
    else if (rej_rd) reject_flag <= 1'b0;
  end

  // R10: single-cycle pulses, never both
  p_page_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    page_go |=> !page_go);
  p_mass_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mass_go |=> !mass_go);
  p_go_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_go && mass_go));
  // R6/R1: a page pulse follows a cycle that was unlocked, armed and idle
  p_page_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    page_go |-> $past(unlocked && page_armed && !busy));
  // R5: a mass pulse needs the debug port and the enable
  p_mass_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mass_go |-> $past(dbg_en && mass_armed && unlocked));
  // R8: the flag holds until read
  p_reject_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_flag && !rej_rd) |=> reject_flag);
  p_reject_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reject_flag) |-> $past(busy));
endmodule

// File: rtl/flash_erase_gate.sv
module flash_erase_gate
  import egate_pkg::*;
#(
  parameter int PAGE_W   = 6,
  parameter int KEY_W    = 4,
  parameter int KEY_OPEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [7:0]        trig_data,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_data,
  input  logic              mass_we,
  input  logic              mass_data,
  input  logic              key_we,
  input  logic [KEY_W-1:0]  key_data,
  input  logic              dbg_port_en,
  input  logic              flash_busy,
  input  logic              reject_rd,
  output logic              page_erase_go,
  output logic [PAGE_W-1:0] page_num,
  output logic              mass_erase_go,
  output logic              page_armed,
  output logic              mass_armed,
  output logic              unlocked,
  output logic [KEY_W-1:0]  unlock_code,
  output logic              reject_flag
);
  erase_req_e        req;
  logic              want_page, want_mass;
  logic              consume;
  logic [PAGE_W-1:0] page_addr;

  egate_decode u_decode (
    .trig_we   (trig_we),
    .trig_data (trig_data),
    .req       (req),
    .want_page (want_page),
    .want_mass (want_mass)
  );

  egate_arming #(.PAGE_W(PAGE_W), .KEY_W(KEY_W), .KEY_OPEN(KEY_OPEN)) u_arming (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_we    (page_we),
    .page_data  (page_data),
    .mass_we    (mass_we),
    .mass_data  (mass_data),
    .key_we     (key_we),
    .key_data   (key_data),
    .consume    (consume),
    .page_armed (page_armed),
    .mass_armed (mass_armed),
    .page_addr  (page_addr),
    .key_code   (unlock_code),
    .unlocked   (unlocked)
  );

  egate_issue #(.PAGE_W(PAGE_W)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .page_armed  (page_armed),
    .mass_armed  (mass_armed),
    .page_addr   (page_addr),
    .unlocked    (unlocked),
    .dbg_en      (dbg_port_en),
    .busy        (flash_busy),
    .rej_rd      (reject_rd),
    .consume     (consume),
    .page_go     (page_erase_go),
    .page_num    (page_num),
    .mass_go     (mass_erase_go),
    .reject_flag (reject_flag)
  );

  // R3: a byte other than the two magic values never yields a request
  p_other_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_data != 8'h55 && trig_data != 8'hAA) |-> (!want_page && !want_mass));
  // R3: an ignored byte leaves the arming flags alone
  p_other_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && trig_data != 8'h55 && trig_data != 8'hAA && !page_we && !mass_we)
      |=> ($stable(page_armed) && $stable(mass_armed)));
endmodule

// File: tb/flash_erase_gate_test.sv
module flash_erase_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_we = 0, page_we = 0, mass_we = 0, key_we = 0;
  logic [7:0] trig_data = 0;
  logic [5:0] page_data = 0;
  logic mass_data = 0;
  logic [3:0] key_data = 0;
  logic dbg_port_en = 0, flash_busy = 0, reject_rd = 0;
  logic page_erase_go, mass_erase_go, page_armed, mass_armed, unlocked, reject_flag;
  logic [5:0] page_num;
  logic [3:0] unlock_code;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_erase_gate uut (
    .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_data(trig_data),
    .page_we(page_we), .page_data(page_data), .mass_we(mass_we), .mass_data(mass_data),
    .key_we(key_we), .key_data(key_data), .dbg_port_en(dbg_port_en),
    .flash_busy(flash_busy), .reject_rd(reject_rd), .page_erase_go(page_erase_go),
    .page_num(page_num), .mass_erase_go(mass_erase_go), .page_armed(page_armed),
    .mass_armed(mass_armed), .unlocked(unlocked), .unlock_code(unlock_code),
    .reject_flag(reject_flag)
  );

  typedef struct packed {
    logic [3:0] key;
    logic       do_page;
    logic [5:0] page;
    logic       do_mass;
    logic       dbg;
    logic       busy;
    logic [7:0] trig;
    logic       exp_pg;
    logic       exp_ms;
    logic       exp_rej;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1, 6'd5,  1'b0, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0}, // R1
    '{4'd2, 1'b1, 6'd63, 1'b0, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0}, // R1 top page
    '{4'd2, 1'b0, 6'd0,  1'b1, 1'b1, 1'b0, 8'hAA, 1'b0, 1'b1, 1'b0}, // R2
    '{4'd2, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b0}, // R5 no debug
    '{4'd2, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b0}, // R5 no enable
    '{4'd2, 1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0}, // R4 no page
    '{4'd3, 1'b1, 6'd9,  1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0}, // R6 key 3
    '{4'd0, 1'b0, 6'd0,  1'b1, 1'b1, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b0}, // R6 key 0
    '{4'd2, 1'b1, 6'd7,  1'b1, 1'b1, 1'b0, 8'h54, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd2, 1'b1, 6'd7,  1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd2, 1'b1, 6'd1,  1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b1}, // R8 page busy
    '{4'd2, 1'b0, 6'd0,  1'b1, 1'b1, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b1}, // R8 mass busy
    '{4'd2, 1'b1, 6'd33, 1'b1, 1'b1, 1'b0, 8'h55, 1'b1, 1'b0, 1'b0}  // R10 page only
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_key(input logic [3:0] v);
    @(negedge clk); key_we = 1; key_data = v;
    @(negedge clk); key_we = 0;
  endtask
  task automatic wr_page(input logic [5:0] v);
    @(negedge clk); page_we = 1; page_data = v;
    @(negedge clk); page_we = 0;
  endtask
  task automatic wr_mass(input logic v);
    @(negedge clk); mass_we = 1; mass_data = v;
    @(negedge clk); mass_we = 0;
  endtask
  task automatic wr_trig(input logic [7:0] v);
    @(negedge clk); trig_we = 1; trig_data = v;
    @(negedge clk); trig_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state, sampled while reset is still held
    chk("R9 go", {page_erase_go, mass_erase_go}, 0);
    chk("R9 flags", {page_armed, mass_armed, unlocked, reject_flag}, 0);
    chk("R9 code", {page_num, unlock_code}, 0);
    rst_n = 1'b1;

    // Table walk: each vector starts from reset
    for (int i = 0; i < NV; i++) begin
      do_reset();
      dbg_port_en = VECS[i].dbg;
      flash_busy  = VECS[i].busy;
      wr_key(VECS[i].key);
      if (VECS[i].do_page) wr_page(VECS[i].page);
      if (VECS[i].do_mass) wr_mass(1'b1);
      wr_trig(VECS[i].trig);
      chk($sformatf("vec%0d page_go", i), page_erase_go, VECS[i].exp_pg);
      chk($sformatf("vec%0d mass_go", i), mass_erase_go, VECS[i].exp_ms);
      chk($sformatf("vec%0d reject", i), reject_flag, VECS[i].exp_rej);
      if (VECS[i].exp_pg) chk($sformatf("vec%0d R1 page_num", i), page_num, VECS[i].page);
      @(negedge clk);
      chk($sformatf("vec%0d R10 pulse ends", i), {page_erase_go, mass_erase_go}, 0);
      flash_busy = 0;
      dbg_port_en = 0;
    end

    // R6: unlock read-back
    do_reset();
    wr_key(4'd2);
    chk("R6 unlocked", {unlocked, unlock_code}, {1'b1, 4'd2});
    wr_key(4'd10);
    chk("R6 locked", {unlocked, unlock_code}, {1'b0, 4'd10});

    // R3: ignored byte keeps arming
    do_reset();
    wr_key(4'd2); wr_page(6'd12); wr_mass(1'b1);
    wr_trig(8'h00);
    chk("R3 arming kept", {page_armed, mass_armed, page_erase_go, mass_erase_go}, 4'b1100);

    // R7: consumption by a page erase clears both flags
    wr_trig(8'h55);
    chk("R7 pulse", {page_erase_go, page_armed, mass_armed}, 3'b100);
    chk("R1 page_num 12", page_num, 6'd12);
    wr_trig(8'h55);
    chk("R7 no re-erase", page_erase_go, 1'b0);
    wr_page(6'd40);
    wr_trig(8'h55);
    chk("R7 re-armed erase", {page_erase_go, page_num}, {1'b1, 6'd40});

    // R7: mass erase consumes page arming too
    dbg_port_en = 1;
    wr_page(6'd3); wr_mass(1'b1);
    wr_trig(8'hAA);
    chk("R7 mass consume", {mass_erase_go, page_armed, mass_armed}, 3'b100);
    wr_trig(8'hAA);
    chk("R7 no re-mass", mass_erase_go, 1'b0);

    // R5: writing 0 disarms the enable
    wr_mass(1'b1); wr_mass(1'b0);
    wr_trig(8'hAA);
    chk("R5 disarmed", {mass_armed, mass_erase_go}, 2'b00);

    // R8: busy rejection keeps arming, read clears, set beats read
    wr_page(6'd8);
    flash_busy = 1;
    wr_trig(8'h55);
    chk("R8 set", {reject_flag, page_armed, page_erase_go}, 3'b110);
    @(negedge clk); trig_we = 1; trig_data = 8'h55; reject_rd = 1;
    @(negedge clk); trig_we = 0; reject_rd = 0;
    chk("R8 set wins", reject_flag, 1'b1);
    @(negedge clk); reject_rd = 1;
    @(negedge clk); reject_rd = 0;
    chk("R8 cleared", reject_flag, 1'b0);
    flash_busy = 0;
    wr_trig(8'h55);
    chk("R8 kept arming used", {page_erase_go, page_num}, {1'b1, 6'd8});

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule